// File: doc/BRIEF.md
# I2S Stereo Transmit Channel

This block is the transmit side of a serial audio port. A host places stereo samples into it through two write strobes: the left sample is held first, and the pair is queued only when the right sample follows. A 16-deep queue of sample pairs decouples the host from the audio timing. The block serializes one pair per frame onto a single data line, most significant bit first, at a resolution chosen by a 3-bit code.

The bit clock and word select come from outside, synchronous to the system clock and much slower than it. A half-frame begins at the falling bit-clock edge where the sampled word select differs from its value at the previous falling edge; word select low marks the left half and high marks the right half. Data changes only after falling bit-clock edges. Two status flags report to the host. The first shows when the queue holds fewer pairs than a programmable level. The second shows that a write was lost because the queue was full; it clears when the host reads it. Each flag has a mask bit that gates its interrupt output.

Top module: `i2s_tx_chan`

## Requirements
- R1: A `wr_left` strobe only holds the left sample. The pair {held left, `wr_data`} enters the queue on the `wr_right` strobe, so a left write alone leaves the fill level unchanged.
- R2: A `wr_left` or `wr_right` strobe while the queue holds 16 pairs is discarded and sets `ovr_raw` one cycle later. `irq_ovr` is `ovr_raw` gated off by `mask_ovr`=1. The discarded pair is never transmitted.
- R3: Each sample is sent MSB first, and a half-frame always spans 32 bit slots. The code `word_len` 1, 2, 3, 4 selects 12, 16, 20, 24 bits; codes 0, 5, 6, 7 select 32 bits. The sample sits in the low bits of `wr_data`. Slots after the last sample bit carry 0.
- R4: Transmission runs only while `glb_en`, `blk_en` and `ch_en` are all 1. When any of them is 0, `sd` is 0 from the next cycle and the queue is not read. After enabling, the first non-zero output comes at the next left half-frame, and the surrounding right half stays 0.
- R5: `empty_raw` is 1 while the fill level is below `trig_lvl`+1 and 0 once it reaches that level. `irq_empty` is `empty_raw` gated off by `mask_empty`=1.
- R6: A `rd_ovr` pulse clears `ovr_raw` in the next cycle, unless a write to a full queue happens in that same cycle, in which case the flag stays set.
- R7: A `flush` pulse empties the queue only while the channel is not enabled (see R4). While the channel is enabled, the pulse has no effect.
- R8: If the queue is empty at the start of a left half-frame, the whole pair for that frame is sent as zeros.
- R9: `sd` changes only in the cycle after a falling bit-clock edge is seen, or after the channel is disabled.
- R10: Pairs leave the queue in the order they were written, one pair per frame, and up to 16 pairs are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Bit clock, synchronous to clk and slower than it |
| ws | input | 1 | Word select: 0 for the left half, 1 for the right half |
| glb_en | input | 1 | Global enable |
| blk_en | input | 1 | Transmitter block enable |
| ch_en | input | 1 | Channel enable |
| word_len | input | 3 | Resolution code |
| trig_lvl | input | 4 | Empty-trigger level minus one |
| flush | input | 1 | Queue flush pulse |
| wr_left | input | 1 | Left sample write strobe |
| wr_right | input | 1 | Right sample write strobe (commits the pair) |
| wr_data | input | 32 | Sample data, right-aligned |
| mask_empty | input | 1 | 1 masks the empty-trigger interrupt |
| mask_ovr | input | 1 | 1 masks the overrun interrupt |
| rd_ovr | input | 1 | Overrun flag read pulse (clears the flag) |
| sd | output | 1 | Serial data out |
| empty_raw | output | 1 | Raw empty-trigger status |
| ovr_raw | output | 1 | Overrun flag |
| irq_empty | output | 1 | Masked empty-trigger interrupt |
| irq_ovr | output | 1 | Masked overrun interrupt |

## Verification
Every cycle, the checker enforces the following:
- the silent output while disabled;
- the edge-only timing of `sd`;
- the bound on the fill level;
- the rule that a left write cannot grow the queue;
- the overrun set and read-clear rules;
- the effect of a flush that is accepted.

Other properties span many frames, so only the bench scenarios can show them:
- the bit order and zero padding for each resolution code;
- the alignment to the next left half-frame;
- the queue order and zero frames when the queue is empty;
- the lost pair after an overrun;
- the flush that is ignored while enabled.

// File: rtl/i2s_tx_chan.sv
module i2s_tx_chan #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck,
  input  logic        ws,
  input  logic        glb_en,
  input  logic        blk_en,
  input  logic        ch_en,
  input  logic [2:0]  word_len,
  input  logic [3:0]  trig_lvl,
  input  logic        flush,
  input  logic        wr_left,
  input  logic        wr_right,
  input  logic [31:0] wr_data,
  input  logic        mask_empty,
  input  logic        mask_ovr,
  input  logic        rd_ovr,
  output logic        sd,
  output logic        empty_raw,
  output logic        ovr_raw,
  output logic        irq_empty,
  output logic        irq_ovr
);
  localparam int DW = 32;
  localparam int AW = $clog2(DEPTH);

  logic [2*DW-1:0] mem [DEPTH];
  logic [AW:0]     wp, rp;
  logic [DW-1:0]   lhold, rhold, sh;
  logic            sck_q, ws_last, active;
  logic [5:0]      res;

  wire [AW:0]     cnt        = wp - rp;
  wire            full       = (cnt == DEPTH[AW:0]);
  wire            emp        = (cnt == '0);
  wire            en_all     = glb_en & blk_en & ch_en;
  wire            fall       = sck_q & ~sck;
  wire            half_start = fall & (ws != ws_last);
  wire            left_start = half_start & ~ws;
  wire            right_start = half_start & ws;
  wire            pop        = en_all & left_start & ~emp;
  wire            push       = wr_right & ~full;
  wire            flush_ok   = flush & ~en_all;
  wire [2*DW-1:0] head       = mem[rp[AW-1:0]];

  always_comb begin
    case (word_len)
      3'd1:    res = 6'd12;
      3'd2:    res = 6'd16;
      3'd3:    res = 6'd20;
      3'd4:    res = 6'd24;
      default: res = 6'd32;
    endcase
  end

  wire [DW-1:0] l_al = pop ? head[2*DW-1:DW] << (6'd32 - res) : '0;
  wire [DW-1:0] r_al = rhold << (6'd32 - res);

  always_ff @(posedge clk) begin
    if (push) mem[wp[AW-1:0]] <= {lhold, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      lhold   <= '0;
      ovr_raw <= 1'b0;
    end else begin
      if (flush_ok) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (push) wp <= wp + 1'b1;
        if (pop)  rp <= rp + 1'b1;
      end
      if (wr_left && !full) lhold <= wr_data;
      if ((wr_left || wr_right) && full) ovr_raw <= 1'b1;
      else if (rd_ovr)                   ovr_raw <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      ws_last <= 1'b1;
      active  <= 1'b0;
      sh      <= '0;
      rhold   <= '0;
      sd      <= 1'b0;
    end else begin
      sck_q <= sck;
      if (fall) ws_last <= ws;
      if (!en_all) begin
        active <= 1'b0;
        sh     <= '0;
        sd     <= 1'b0;
      end else if (fall) begin
        if (left_start) begin
          active <= 1'b1;
          sd     <= l_al[DW-1];
          sh     <= l_al << 1;
          rhold  <= pop ? head[DW-1:0] : '0;
        end else if (right_start && active) begin
          sd <= r_al[DW-1];
          sh <= r_al << 1;
        end else if (active) begin
          sd <= sh[DW-1];
          sh <= sh << 1;
        end
      end
    end
  end

  assign empty_raw = (cnt <= {1'b0, trig_lvl});
  assign irq_empty = empty_raw & ~mask_empty;
  assign irq_ovr   = ovr_raw & ~mask_ovr;
endmodule

// File: rtl/i2s_tx_chan_chk.sv
module i2s_tx_chan_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sck,
  input logic                       sck_q,
  input logic                       sd,
  input logic                       glb_en,
  input logic                       blk_en,
  input logic                       ch_en,
  input logic                       wr_left,
  input logic                       wr_right,
  input logic                       rd_ovr,
  input logic                       flush,
  input logic                       ovr_raw,
  input logic                       empty_raw,
  input logic [$clog2(DEPTH):0]     cnt
);
  wire en = glb_en & blk_en & ch_en;
  wire wr_full = (wr_left | wr_right) & (cnt == DEPTH);

  a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sd);
  a_r9_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd) |-> ($past(sck_q && !sck) || !$past(en)));
  a_r10_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= DEPTH);
  a_r1_left_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_left && !wr_right) |=> cnt <= $past(cnt));
  a_r2_full_sets_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_right && cnt == DEPTH) |=> ovr_raw);
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ovr && !wr_full) |=> !ovr_raw);
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !en) |=> (cnt == 0 && empty_raw));
endmodule

bind i2s_tx_chan i2s_tx_chan_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .sck_q(sck_q), .sd(sd),
  .glb_en(glb_en), .blk_en(blk_en), .ch_en(ch_en),
  .wr_left(wr_left), .wr_right(wr_right), .rd_ovr(rd_ovr), .flush(flush),
  .ovr_raw(ovr_raw), .empty_raw(empty_raw), .cnt(cnt)
);

// File: tb/sim_i2s_tx_chan.sv
`timescale 1ns/1ps
module sim_i2s_tx_chan;
  logic clk = 0, rst_n = 0;
  logic sck = 0, ws = 1, glb_en = 0, blk_en = 0, ch_en = 0;
  logic [2:0] word_len = 0;
  logic [3:0] trig_lvl = 0;
  logic flush = 0, wr_left = 0, wr_right = 0, mask_empty = 0, mask_ovr = 0, rd_ovr = 0;
  logic [31:0] wr_data = 0;
  logic sd, empty_raw, ovr_raw, irq_empty, irq_ovr;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2s_tx_chan u0 (.*);

  localparam int NV = 7;
  localparam logic [2:0]  VL [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd7};
  localparam logic [31:0] VA [NV] = '{32'hA5C3_9E17, 32'h0000_0B6D, 32'hFFFF_8001,
                                      32'h000C_3A5F, 32'hDE9A_7C21, 32'h8000_0001, 32'h1234_5678};
  localparam logic [31:0] VB [NV] = '{32'h5A3C_61E8, 32'hFFFF_F4A2, 32'h0000_7FFE,
                                      32'hFFF3_C5A0, 32'h0165_83DE, 32'h7FFF_FFFE, 32'h8765_4321};

  function automatic logic [31:0] expect_slot(input logic [31:0] w, input logic [2:0] code);
    int r;
    logic [31:0] o;
    case (code)
      3'd1: r = 12;
      3'd2: r = 16;
      3'd3: r = 20;
      3'd4: r = 24;
      default: r = 32;
    endcase
    o = '0;
    for (int j = 0; j < r; j++) o[31-j] = w[r-1-j];
    return o;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_pair(input logic [31:0] l, input logic [31:0] r);
    wr_left = 1; wr_data = l; tick(1); wr_left = 0;
    wr_right = 1; wr_data = r; tick(1); wr_right = 0;
  endtask

  task automatic half(input logic w, output logic [31:0] bits);
    for (int j = 0; j < 32; j++) begin
      sck = 1; ws = w; tick(4);
      sck = 0; tick(4);
      bits[31-j] = sd;
    end
  endtask

  task automatic pulse_flush;
    flush = 1; tick(1); flush = 0; tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    tick(3); rst_n = 1; tick(2);
    chk("R4 reset sd", {31'd0, sd}, 32'd0);
    chk("R5 reset empty_raw", {31'd0, empty_raw}, 32'd1);
    chk("R5 reset irq_empty", {31'd0, irq_empty}, 32'd1);
    chk("R6 reset ovr_raw", {31'd0, ovr_raw}, 32'd0);

    glb_en = 1; blk_en = 1;
    for (int i = 0; i < NV; i++) begin
      ch_en = 0; word_len = VL[i]; tick(1);
      wr_pair(VA[i], VB[i]);
      ch_en = 1;
      half(1, got); chk("R4 right half before first left", got, 32'd0);
      half(0, got); chk("R3 left slot", got, expect_slot(VA[i], VL[i]));
      half(1, got); chk("R3 right slot", got, expect_slot(VB[i], VL[i]));
    end
    ch_en = 0; tick(2);

    trig_lvl = 4'd1;
    wr_left = 1; wr_data = 32'h1; tick(1); wr_left = 0; tick(1);
    chk("R1 left write alone not queued", {31'd0, empty_raw}, 32'd1);
    mask_empty = 1; tick(1);
    chk("R5 masked irq_empty", {31'd0, irq_empty}, 32'd0);
    mask_empty = 0;
    wr_right = 1; wr_data = 32'h2; tick(1); wr_right = 0; tick(1);
    chk("R5 below level", {31'd0, empty_raw}, 32'd1);
    wr_pair(32'h3, 32'h4); tick(1);
    chk("R5 level reached", {31'd0, empty_raw}, 32'd0);
    chk("R5 irq follows raw", {31'd0, irq_empty}, 32'd0);

    ch_en = 1; tick(1); pulse_flush;
    chk("R7 flush ignored while enabled", {31'd0, empty_raw}, 32'd0);
    ch_en = 0; tick(1); pulse_flush;
    chk("R7 flush while disabled", {31'd0, empty_raw}, 32'd1);

    trig_lvl = 4'd15; word_len = 3'd5;
    for (int k = 0; k < 16; k++) wr_pair(32'hC000_0000 + k, 32'h3000_0000 + k);
    tick(1);
    chk("R10 sixteen pairs held", {31'd0, empty_raw}, 32'd0);
    chk("R2 no overrun yet", {31'd0, ovr_raw}, 32'd0);
    wr_pair(32'hDEAD_BEEF, 32'hBAD0_F00D); tick(1);
    chk("R2 overrun set", {31'd0, ovr_raw}, 32'd1);
    chk("R2 irq_ovr", {31'd0, irq_ovr}, 32'd1);
    mask_ovr = 1; tick(1);
    chk("R2 masked irq_ovr", {31'd0, irq_ovr}, 32'd0);
    mask_ovr = 0;
    rd_ovr = 1; tick(1); rd_ovr = 0; tick(1);
    chk("R6 read clears overrun", {31'd0, ovr_raw}, 32'd0);
    ch_en = 1;
    half(1, got);
    for (int k = 0; k < 16; k++) begin
      half(0, got); chk("R10 order left", got, 32'hC000_0000 + k);
      half(1, got); chk("R10 order right", got, 32'h3000_0000 + k);
    end
    half(0, got); chk("R8 empty left zero / R2 dropped", got, 32'd0);
    half(1, got); chk("R8 empty right zero", got, 32'd0);

    ch_en = 0; trig_lvl = 4'd0; word_len = 3'd2; tick(1);
    wr_pair(32'h0000_ABCD, 32'h0000_1357);
    glb_en = 0; ch_en = 1;
    half(1, got); half(0, got);
    chk("R4 global disable silences", got, 32'd0);
    chk("R4 global disable keeps queue", {31'd0, empty_raw}, 32'd0);
    glb_en = 1;
    half(1, got); chk("R4 waits for left half", got, 32'd0);
    half(0, got); chk("R4 left after enable", got, 32'hABCD_0000);
    half(1, got); chk("R4 right after enable", got, 32'h1357_0000);
    blk_en = 0; tick(2);
    chk("R4 block disable silences", {31'd0, sd}, 32'd0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule